// File: doc/BRIEF.md
# Byte-Wide Parallel Flash Command Interpreter

This block is a device-side model of a flash memory that is controlled by writing command bytes over a simple synchronous byte bus. A write with chip select and write strobe high hands one command or data byte to the interpreter. A read with chip select and read strobe high returns a byte whose meaning depends on the current read view. The array view returns stored data. The identifier view returns the vendor code, the device code and the lock configuration. The status view returns the status byte.

The device holds a small byte array divided into equal blocks, a lock bit per block and a master lock fixed by a parameter. Erase, program and lock-clear operations take two bus writes. Erase and program then keep the device busy for a parameterised number of cycles. Reads are combinational from registered state, so a read returns in the same cycle it is issued. While no read is in progress, `rdata` is zero.

Top module: `pflash_cmd_unit`

## Requirements
- R1: After reset the device is in the array view, every array byte reads 0xFF, and the status byte reads 0x80.
- R2: A write of 0xFF at any address, including as the second byte of a two-write sequence, selects the array view and drops the pending sequence without touching the array or the status.
- R3: After a write of 0x90 the identifier view returns the vendor code MFR_ID at address 0 and DEV_ID at address 1 shifted left by ID_SHIFT. The vendor code has an odd number of one bits.
- R4: In the identifier view, address 3 reads 0x01 if the master lock is set and 0x00 otherwise. Address block_base+2 reads 0x01 for a locked block and 0x00 for an unlocked one.
- R5: After a write of 0x70 every read returns the status byte. Bit 7 is ready, bit 5 is erase error, bit 4 is program error and bit 1 is lock error. Bits 6, 3, 2 and 0 read 0.
- R6: A write of 0x50 clears status bits 5, 4 and 1 and leaves the read view unchanged.
- R7: Writing 0x40 and then a data byte D to address A stores old(A) AND D at A, and selects the status view.
- R8: Writing 0x20 and then 0xD0 to an address sets every byte of that address's block to 0xFF. Other blocks are left unchanged.
- R9: An accepted erase or program clears status bit 7 for exactly BUSY_CYC cycles. Writes are ignored while bit 7 is clear.
- R10: If the second write of an erase or lock-clear sequence is not 0xD0 (and not 0xFF), status bits 5 and 4 are set and the array is unchanged.
- R11: An erase or program aimed at a locked block sets bit 1, together with bit 5 for an erase or bit 4 for a program. The array is left unchanged and no busy time starts.
- R12: Writing 0x60 and then 0xD0 clears all block locks when the master lock is clear. When the master lock is set, the locks stay as they are and status bit 1 is set.
- R13: A first write with any code outside the command set leaves the read view and the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select |
| we | input | 1 | Write strobe; the byte is taken at the rising edge |
| re | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Command or data byte |
| rdata | output | 8 | Read byte for the current view; 0 when not reading |

## Verification
A command written at a rising edge is visible on a read issued in the next cycle, because reads are combinational from the registered view, status and array. The bench therefore drives each write from one falling edge to the next and samples each read 1 ns after the falling edge where it is driven. The busy window is due for exactly BUSY_CYC cycles after the confirming write. The bench counts the polls up to the first ready status and expects exactly BUSY_CYC of them. Results that depend on error flags are read on the first read after the sequence, which is also where the absence of busy time is checked.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {M_ARRAY, M_ID, M_STAT} rd_mode_e;
  typedef enum logic [1:0] {P_NONE, P_ERASE, P_PROG, P_UNLK} pend_e;

  localparam logic [7:0] OP_RESET   = 8'hFF;
  localparam logic [7:0] OP_ID      = 8'h90;
  localparam logic [7:0] OP_STAT    = 8'h70;
  localparam logic [7:0] OP_CLR     = 8'h50;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROG    = 8'h40;
  localparam logic [7:0] OP_UNLK    = 8'h60;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
endpackage

// File: rtl/pfc_rst_sync.sv
module pfc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
  import pfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok,
  input  logic [7:0] wdata,
  input  logic       blk_locked,
  input  logic       master,
  output rd_mode_e   mode_q,
  output pend_e      pend_q,
  output logic       err_erase_q,
  output logic       err_prog_q,
  output logic       err_lock_q,
  output logic       erase_go,
  output logic       prog_go,
  output logic       unlk_go
);
  rd_mode_e mode_d;
  pend_e    pend_d;
  logic     ee_d, ep_d, el_d;
  logic     is_confirm;

  assign is_confirm = (wdata == OP_CONFIRM);

  always_comb begin
    mode_d   = mode_q;
    pend_d   = pend_q;
    ee_d     = err_erase_q;
    ep_d     = err_prog_q;
    el_d     = err_lock_q;
    erase_go = 1'b0;
    prog_go  = 1'b0;
    unlk_go  = 1'b0;
    if (wr_ok) begin
      if (wdata == OP_RESET) begin
        mode_d = M_ARRAY;
        pend_d = P_NONE;
      end else begin
        case (pend_q)
          P_ERASE: begin
            pend_d = P_NONE;
            mode_d = M_STAT;
            if (!is_confirm) begin
              ee_d = 1'b1;
              ep_d = 1'b1;
            end else if (blk_locked) begin
              ee_d = 1'b1;
              el_d = 1'b1;
            end else begin
              erase_go = 1'b1;
            end
          end
          P_PROG: begin
            pend_d = P_NONE;
            mode_d = M_STAT;
            if (blk_locked) begin
              ep_d = 1'b1;
              el_d = 1'b1;
            end else begin
              prog_go = 1'b1;
            end
          end
          P_UNLK: begin
            pend_d = P_NONE;
            mode_d = M_STAT;
            if (!is_confirm) begin
              ee_d = 1'b1;
              ep_d = 1'b1;
            end else if (master) begin
              el_d = 1'b1;
            end else begin
              unlk_go = 1'b1;
            end
          end
          default: begin
            case (wdata)
              OP_ID:    mode_d = M_ID;
              OP_STAT:  mode_d = M_STAT;
              OP_CLR: begin
                ee_d = 1'b0;
                ep_d = 1'b0;
                el_d = 1'b0;
              end
              OP_ERASE: pend_d = P_ERASE;
              OP_PROG:  pend_d = P_PROG;
              OP_UNLK:  pend_d = P_UNLK;
              default:  ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= M_ARRAY;
      pend_q      <= P_NONE;
      err_erase_q <= 1'b0;
      err_prog_q  <= 1'b0;
      err_lock_q  <= 1'b0;
    end else if (wr_ok) begin
      mode_q      <= mode_d;
      pend_q      <= pend_d;
      err_erase_q <= ee_d;
      err_prog_q  <= ep_d;
      err_lock_q  <= el_d;
    end
  end
endmodule

// File: rtl/pfc_busy_timer.sv
module pfc_busy_timer #(
  parameter int unsigned BUSY_CYC = 8,
  localparam int unsigned CNT_W   = $clog2(BUSY_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] cnt_q,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = start || busy;

  always_comb begin
    if (start) cnt_d = CNT_W'(BUSY_CYC);
    else       cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pfc_store.sv
module pfc_store #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BLK_W     = 6,
  parameter logic [31:0] LOCK_INIT = 32'h0,
  localparam int unsigned NWORD    = 2 ** ADDR_W,
  localparam int unsigned NBLK     = 2 ** (ADDR_W - BLK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              erase_go,
  input  logic              prog_go,
  input  logic              unlk_go,
  output logic [7:0]        arr_byte,
  output logic [NBLK-1:0]   lock_q
);
  logic [7:0] word_v [NWORD];

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(g);
    logic       hit_erase, hit_prog, word_en;
    logic [7:0] word_q, word_d;

    assign hit_erase = erase_go && (WADDR[ADDR_W-1:BLK_W] == addr[ADDR_W-1:BLK_W]);
    assign hit_prog  = prog_go && (WADDR == addr);
    assign word_en   = hit_erase || hit_prog;
    assign word_d    = hit_erase ? 8'hFF : (word_q & wdata);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= 8'hFF;
      else if (word_en) word_q <= word_d;
    end

    assign word_v[g] = word_q;
  end

  assign arr_byte = word_v[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= LOCK_INIT[NBLK-1:0];
    else if (unlk_go) lock_q <= '0;
  end
endmodule

// File: rtl/pfc_rdmux.sv
module pfc_rdmux
  import pfc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BLK_W    = 6,
  parameter int unsigned ID_SHIFT = 0,
  parameter logic [7:0]  MFR_ID   = 8'h89,
  parameter logic [7:0]  DEV_ID   = 8'hA2,
  localparam int unsigned NBLK    = 2 ** (ADDR_W - BLK_W)
) (
  input  logic              rd_en,
  input  logic              busy,
  input  rd_mode_e          mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        arr_byte,
  input  logic [7:0]        stat_byte,
  input  logic              master,
  input  logic [NBLK-1:0]   lock_vec,
  output logic [7:0]        rdata
);
  localparam logic [ADDR_W-1:0] MFR_A = '0;
  localparam logic [ADDR_W-1:0] DEV_A = ADDR_W'(1 << ID_SHIFT);
  localparam logic [ADDR_W-1:0] MST_A = ADDR_W'(3);
  localparam logic [BLK_W-1:0]  LCK_O = BLK_W'(2);

  logic [7:0] id_byte;

  always_comb begin
    if (addr == MFR_A)                 id_byte = MFR_ID;
    else if (addr == DEV_A)            id_byte = DEV_ID;
    else if (addr == MST_A)            id_byte = {7'd0, master};
    else if (addr[BLK_W-1:0] == LCK_O) id_byte = {7'd0, lock_vec[addr[ADDR_W-1:BLK_W]]};
    else                               id_byte = 8'h00;
  end

  always_comb begin
    if (!rd_en)              rdata = 8'h00;
    else if (busy)           rdata = stat_byte;
    else begin
      case (mode)
        M_ARRAY: rdata = arr_byte;
        M_ID:    rdata = id_byte;
        default: rdata = stat_byte;
      endcase
    end
  end
endmodule

// File: rtl/pflash_cmd_unit.sv
module pflash_cmd_unit
  import pfc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BLK_W       = 6,
  parameter int unsigned BUSY_CYC    = 8,
  parameter int unsigned ID_SHIFT    = 0,
  parameter logic [7:0]  MFR_ID      = 8'h89,
  parameter logic [7:0]  DEV_ID      = 8'hA2,
  parameter logic [31:0] LOCK_INIT   = 32'h4,
  parameter bit          MASTER_LOCK = 1'b0,
  localparam int unsigned NBLK       = 2 ** (ADDR_W - BLK_W),
  localparam int unsigned CNT_W      = $clog2(BUSY_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic             rst_sync_n;
  logic             busy, wr_ok, blk_locked, master;
  logic [CNT_W-1:0] busy_cnt;
  rd_mode_e         mode;
  pend_e            pend;
  logic             err_erase, err_prog, err_lock;
  logic             erase_go, prog_go, unlk_go;
  logic [7:0]       arr_byte, stat_byte;
  logic [NBLK-1:0]  lock_vec;

  assign master     = MASTER_LOCK;
  assign wr_ok      = cs && we && !busy;
  assign blk_locked = lock_vec[addr[ADDR_W-1:BLK_W]];
  assign stat_byte  = {!busy, 1'b0, err_erase, err_prog, 2'b00, err_lock, 1'b0};

  pfc_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  pfc_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .wr_ok(wr_ok), .wdata(wdata),
    .blk_locked(blk_locked), .master(master),
    .mode_q(mode), .pend_q(pend),
    .err_erase_q(err_erase), .err_prog_q(err_prog), .err_lock_q(err_lock),
    .erase_go(erase_go), .prog_go(prog_go), .unlk_go(unlk_go)
  );

  pfc_busy_timer #(.BUSY_CYC(BUSY_CYC)) i_busy (
    .clk(clk), .rst_n(rst_sync_n), .start(erase_go || prog_go),
    .cnt_q(busy_cnt), .busy(busy)
  );

  pfc_store #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .LOCK_INIT(LOCK_INIT)) i_store (
    .clk(clk), .rst_n(rst_sync_n), .addr(addr), .wdata(wdata),
    .erase_go(erase_go), .prog_go(prog_go), .unlk_go(unlk_go),
    .arr_byte(arr_byte), .lock_q(lock_vec)
  );

  pfc_rdmux #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .ID_SHIFT(ID_SHIFT),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) i_rdmux (
    .rd_en(cs && re), .busy(busy), .mode(mode), .addr(addr),
    .arr_byte(arr_byte), .stat_byte(stat_byte), .master(master),
    .lock_vec(lock_vec), .rdata(rdata)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker
  import pfc_pkg::*;
#(
  parameter int unsigned NBLK  = 4,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             we,
  input logic             re,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic             busy,
  input logic [CNT_W-1:0] busy_cnt,
  input rd_mode_e         mode,
  input pend_e            pend,
  input logic [7:0]       stat_byte,
  input logic             blk_locked,
  input logic             master,
  input logic [NBLK-1:0]  lock_vec
);
  p_busy_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cs && re |-> rdata[7] == 1'b0);

  p_busy_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy_cnt == $past(busy_cnt) - CNT_W'(1));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cs && we |=> $stable(mode) && $stable(pend));

  p_reset_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs && we && !busy && wdata == OP_RESET |=> mode == M_ARRAY && pend == P_NONE);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs && we && !busy && pend == P_NONE && wdata == OP_CLR
    |=> stat_byte[5] == 1'b0 && stat_byte[4] == 1'b0 && stat_byte[1] == 1'b0 && $stable(mode));

  p_locked_erase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs && we && !busy && pend == P_ERASE && wdata == OP_CONFIRM && blk_locked
    |=> !busy && stat_byte[1] && stat_byte[5]);

  p_master_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    master && cs && we && !busy && pend == P_UNLK |=> lock_vec == $past(lock_vec));
endmodule

bind pflash_cmd_unit pfc_checker #(.NBLK(NBLK), .CNT_W(CNT_W)) i_pfc_checker (
  .clk(clk), .rst_n(rst_sync_n), .cs(cs), .we(we), .re(re),
  .wdata(wdata), .rdata(rdata), .busy(busy), .busy_cnt(busy_cnt),
  .mode(mode), .pend(pend), .stat_byte(stat_byte),
  .blk_locked(blk_locked), .master(master), .lock_vec(lock_vec)
);

// File: tb/test_pflash_cmd_unit.sv
`timescale 1ns/1ps
module test_pflash_cmd_unit;
  localparam int BUSY = 8;
  localparam int AW   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_a = 1'b0, cs_b = 1'b0, we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata_a, rdata_b;
  logic          sel = 1'b0;
  int            n_chk = 0, n_bad = 0;
  logic [7:0]    mem_m [256];

  always #2.5 clk = ~clk;

  pflash_cmd_unit #(.ADDR_W(AW), .BLK_W(6), .BUSY_CYC(BUSY), .ID_SHIFT(0),
    .MFR_ID(8'h89), .DEV_ID(8'hA2), .LOCK_INIT(32'h4), .MASTER_LOCK(1'b0))
  i_pflash_cmd_unit (.clk(clk), .rst_n(rst_n), .cs(cs_a), .we(we), .re(re),
    .addr(addr), .wdata(wdata), .rdata(rdata_a));

  pflash_cmd_unit #(.ADDR_W(AW), .BLK_W(6), .BUSY_CYC(BUSY), .ID_SHIFT(0),
    .MFR_ID(8'h89), .DEV_ID(8'hA2), .LOCK_INIT(32'h3), .MASTER_LOCK(1'b1))
  i_pflash_cmd_unit_ml (.clk(clk), .rst_n(rst_n), .cs(cs_b), .we(we), .re(re),
    .addr(addr), .wdata(wdata), .rdata(rdata_b));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_a = !sel; cs_b = sel; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs_a = 1'b0; cs_b = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    cs_a = !sel; cs_b = sel; re = 1'b1; addr = a;
    #1 v = sel ? rdata_b : rdata_a;
    cs_a = 1'b0; cs_b = 1'b0; re = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wait_ready(output int n);
    logic [7:0] v;
    n = 0;
    for (int k = 0; k < BUSY + 4; k++) begin
      rd(8'h00, v);
      n++;
      if (v[7]) break;
    end
  endtask

  task automatic program_byte(input logic [7:0] a, input logic [7:0] d);
    int n;
    wr(a, 8'h40);
    wr(a, d);
    wait_ready(n);
    chk("R9 program busy cycles", 8'(n), 8'(BUSY));
    mem_m[a] = mem_m[a] & d;
  endtask

  task automatic erase_block(input logic [7:0] a);
    int n;
    wr(a, 8'h20);
    wr(a, 8'hD0);
    wait_ready(n);
    chk("R9 erase busy cycles", 8'(n), 8'(BUSY));
    for (int i = 0; i < 64; i++) mem_m[{a[7:6], 6'(i)}] = 8'hFF;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk("R1 array after reset", 8'h10, 8'hFF);
    wr(8'h00, 8'h70);
    rd_chk("R1 R5 status after reset", 8'h00, 8'h80);

    // R13 unknown codes
    wr(8'h00, 8'h12);
    rd_chk("R13 status view kept", 8'h00, 8'h80);
    wr(8'h00, 8'hFF);
    wr(8'h00, 8'h12);
    rd_chk("R13 array view kept", 8'h05, 8'hFF);

    // R3 R4 identifier view
    wr(8'h00, 8'h90);
    rd(8'h00, v);
    chk("R3 vendor code", v, 8'h89);
    chk("R3 vendor parity", 8'($countones(v) % 2), 8'd1);
    rd_chk("R3 device code", 8'h01, 8'hA2);
    rd_chk("R4 master lock", 8'h03, 8'h00);
    rd_chk("R4 locked block 2", 8'h82, 8'h01);
    rd_chk("R4 unlocked block 1", 8'h42, 8'h00);

    // R7 program, R9 busy count
    wr(8'h00, 8'hFF);
    program_byte(8'h05, 8'hA5);
    rd_chk("R7 status view after program", 8'h33, 8'h80);
    wr(8'h00, 8'hFF);
    rd_chk("R7 programmed byte", 8'h05, 8'hA5);
    program_byte(8'h05, 8'h0F);
    wr(8'h00, 8'hFF);
    rd_chk("R7 AND with old byte", 8'h05, 8'h05);

    // R9 writes ignored while busy
    wr(8'h06, 8'h40);
    wr(8'h06, 8'h3C);
    wr(8'h00, 8'hFF);
    wait_ready(n);
    mem_m[8'h06] = 8'h3C;
    rd_chk("R9 reset ignored while busy", 8'h00, 8'h80);
    wr(8'h00, 8'hFF);
    rd_chk("R9 byte stored", 8'h06, 8'h3C);

    // R2 reset cancels pending erase
    wr(8'h00, 8'h20);
    wr(8'h00, 8'hFF);
    rd_chk("R2 no erase, array view", 8'h05, 8'h05);
    wr(8'h00, 8'h70);
    rd_chk("R2 no error", 8'h00, 8'h80);

    // R10 bad confirm
    wr(8'h05, 8'h20);
    wr(8'h05, 8'h33);
    rd_chk("R10 erase bad confirm", 8'h00, 8'hB0);
    wr(8'h00, 8'hFF);
    rd_chk("R10 array unchanged", 8'h05, 8'h05);
    // R6 clear keeps view
    wr(8'h00, 8'h50);
    rd_chk("R6 view kept after clear", 8'h05, 8'h05);
    wr(8'h00, 8'h70);
    rd_chk("R6 flags cleared", 8'h00, 8'h80);

    // R11 locked block
    wr(8'h85, 8'h20);
    wr(8'h85, 8'hD0);
    rd_chk("R11 locked erase flags", 8'h00, 8'hA2);
    wr(8'h00, 8'h50);
    wr(8'h90, 8'h40);
    wr(8'h90, 8'h00);
    rd_chk("R11 locked program flags", 8'h00, 8'h92);
    wr(8'h00, 8'hFF);
    rd_chk("R11 locked byte unchanged", 8'h90, 8'hFF);
    wr(8'h00, 8'h50);

    // R8 erase block 0, block 1 untouched
    wr(8'h00, 8'hFF);
    program_byte(8'h45, 8'h11);
    erase_block(8'h20);
    wr(8'h00, 8'hFF);
    rd_chk("R8 erased byte 05", 8'h05, 8'hFF);
    rd_chk("R8 erased byte 06", 8'h06, 8'hFF);
    rd_chk("R8 other block kept", 8'h45, 8'h11);

    // R10 bad confirm on lock clear
    wr(8'h00, 8'h60);
    wr(8'h00, 8'h44);
    rd_chk("R10 unlock bad confirm", 8'h00, 8'hB0);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h90);
    rd_chk("R10 lock kept", 8'h82, 8'h01);

    // R12 unlock with master clear
    wr(8'h00, 8'h60);
    wr(8'h00, 8'hD0);
    rd_chk("R12 unlock status", 8'h00, 8'h80);
    wr(8'h00, 8'h90);
    rd_chk("R12 block 2 unlocked", 8'h82, 8'h00);
    wr(8'h00, 8'hFF);
    program_byte(8'h90, 8'h5A);
    wr(8'h00, 8'hFF);
    rd_chk("R12 program after unlock", 8'h90, 8'h5A);

    // random mix of programs and erases against the model
    begin
      int unused_seed;
      unused_seed = $urandom(32'h1234);
    end
    for (int it = 0; it < 40; it++) begin
      logic [7:0] a, d;
      a = 8'($urandom);
      d = 8'($urandom);
      if (d == 8'hFF) d = 8'hFE;
      if (it % 13 == 12) erase_block(a);
      else program_byte(a, d);
      wr(8'h00, 8'hFF);
      a = 8'($urandom);
      rd_chk("R7 R8 random readback", a, mem_m[a]);
    end
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a;
      a = 8'($urandom);
      rd_chk("R7 R8 final sweep", a, mem_m[a]);
    end

    // R12 master lock set: locks stay, bit 1 set
    sel = 1'b1;
    wr(8'h00, 8'h90);
    rd_chk("R4 master lock set", 8'h03, 8'h01);
    wr(8'h00, 8'h60);
    wr(8'h00, 8'hD0);
    rd_chk("R12 master blocks unlock", 8'h00, 8'h82);
    wr(8'h00, 8'h90);
    rd_chk("R12 block 0 still locked", 8'h02, 8'h01);
    rd_chk("R12 block 1 still locked", 8'h42, 8'h01);

    finish_run();
  end
endmodule